// File: doc/BRIEF.md
# Write Leveling Exit Sequencer

This block sits in a DDR3 memory controller and brings one rank out of write leveling. Once the leveling sweep has seen its final DQS rising edge, the controller pulses `start`. The sequencer then takes control of four things: the DQS drive enable, the ODT pin, the command bus, and the DQ-valid mask.

The teardown runs in a fixed order:

1. DQS stays driven long enough for the last leveling result to be captured.
2. ODT is pulled low so that its turn-off latency ends at the moment DQS is released.
3. The sequencer waits for the input setup time and the termination turn-off time.
4. It issues a single mode-register write to MR1 with the write-leveling enable bit cleared.
5. It then opens two release gates in turn: first a flag that allows further mode-register writes, then a flag that allows any command.

All timing values are inputs counted in clock cycles, so one netlist serves every speed grade. A one-cycle `done` pulse carries the rank index that was captured at `start`. A multi-rank controller can use it to move on to the next rank.

Top module: `wlvl_exit_seq`

In the requirements, cycle t is the state of the outputs just after the t-th rising edge that follows the edge sampling `start` (the sampling edge itself is t = 0). The following shorthands are used:

- W = t_wlo + t_wloe and H = max(W,1).
- I = max(t_is,1) and A = max(t_aof,1).
- S = H + I + A.
- Mr = max(t_mrd,1) and Mo = max(t_mod, Mr).

## Requirements
- R1: While `rst` is high, and after it until the first `start`, `dqs_drive_en`, `odt`, `mrs_ok`, `cmd_ok`, `done` and `dq_valid` are 0, `cmd` is NOP (3'b111), and `ba`, `addr` and `done_rank` are 0.
- R2: `dqs_drive_en` is 1 exactly for cycles 1 to H and 0 otherwise.
- R3: `odt` is 1 exactly for cycles 1 to W - t_odtl_off (never, if that is below 1). It is therefore low for min(t_odtl_off,W) cycles before DQS is released, and it stays low until the next `start`.
- R4: `cmd` is MRS (3'b000) in cycle S+1 only, which is I + A cycles after DQS is released. In every other cycle it is NOP (3'b111).
- R5: In the MRS cycle, `ba` is 1 (MR1) and `addr` equals `mr1_image` with bit 7 forced to 0. In NOP cycles, `ba` and `addr` are 0.
- R6: `mrs_ok` rises in cycle S+1+Mr, which is Mr cycles after the MRS.
- R7: `cmd_ok` rises in cycle S+1+Mo. `done` is 1 in that cycle only, and `done_rank` then equals the `rank_in` sampled with `start`.
- R8: `dq_valid` is 1 in cycles 1 to H, 0 from cycle H+1 up to cycle S+Mo, and 1 again from cycle S+1+Mo.
- R9: A `start` pulse that arrives before the sequence has finished is ignored. All outputs follow the timeline of the first `start`, exactly one MRS is issued, and `done_rank` keeps the first rank.
- R10: `mrs_ok`, `cmd_ok` and `dq_valid` stay 1 after `done` until the next accepted `start`. That `start` clears `mrs_ok` and `cmd_ok` from cycle 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse after the last leveling DQS edge |
| rank_in | input | RANK_W | Rank being leveled, captured at start |
| mr1_image | input | ADDR_W | Stored MR1 contents |
| t_wlo | input | CNT_W | Leveling output delay, cycles |
| t_wloe | input | CNT_W | Extra capture margin, cycles |
| t_odtl_off | input | CNT_W | ODT turn-off latency, cycles |
| t_aof | input | CNT_W | Termination turn-off time, cycles |
| t_is | input | CNT_W | ODT setup time, cycles |
| t_mrd | input | CNT_W | MRS-to-MRS delay, cycles |
| t_mod | input | CNT_W | MRS-to-any-command delay, cycles |
| dqs_drive_en | output | 1 | Controller drives DQS |
| odt | output | 1 | ODT pin level |
| cmd | output | 3 | {RAS#,CAS#,WE#} command code |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Address bus |
| dq_valid | output | 1 | DQ may be trusted |
| mrs_ok | output | 1 | Further mode-register writes allowed |
| cmd_ok | output | 1 | Any command allowed |
| done | output | 1 | One-cycle completion pulse |
| done_rank | output | RANK_W | Rank echoed with done |

## Verification
Two events can fall on the same edge. When t_odtl_off is 0, ODT and DQS drive drop together. When t_mod is not above t_mrd, `mrs_ok`, `cmd_ok` and `done` all rise together. The sweep walks t_odtl_off from 0 past W and t_mod from 0 to above t_mrd, so both the coincident and the separated cases occur. In every cycle each output is compared with the timeline computed from the formulas above, which shows whether a shared edge was produced exactly once and in the right cycle.

// File: rtl/wlx_pkg.sv
package wlx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOLD,
    ST_TIS,
    ST_AOF,
    ST_MRS,
    ST_POST
  } wlx_state_e;

  // {RAS#, CAS#, WE#}
  localparam logic [2:0] CMD_NOP = 3'b111;
  localparam logic [2:0] CMD_MRS = 3'b000;
  localparam int         MR1_SEL = 1;
  localparam int         WL_EN_BIT = 7;
endpackage

// File: rtl/wlx_phase_timer.sv
module wlx_phase_timer #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         last
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - W'(1);
  end

  assign cnt  = cnt_q;
  // a phase ends on the cycle its count is 1 or 0
  assign last = (cnt_q <= W'(1));
endmodule

// File: rtl/wlx_seq_fsm.sv
module wlx_seq_fsm
  import wlx_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int RANK_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [RANK_W-1:0] rank_in,
  input  logic [CNT_W-1:0]  t_wlo,
  input  logic [CNT_W-1:0]  t_wloe,
  input  logic [CNT_W-1:0]  t_odtl_off,
  input  logic [CNT_W-1:0]  t_aof,
  input  logic [CNT_W-1:0]  t_is,
  input  logic [CNT_W-1:0]  t_mrd,
  input  logic [CNT_W-1:0]  t_mod,
  output logic              dqs_d,
  output logic              odt_d,
  output logic              mrs_d,
  output logic              mrs_ok_d,
  output logic              cmd_ok_d,
  output logic              done_d,
  output logic              dq_valid_d,
  output logic [RANK_W-1:0] rank_q
);
  localparam int TW = CNT_W + 1;

  wlx_state_e     state, nxt;
  logic           ld;
  logic [TW-1:0]  ld_val;
  logic [TW-1:0]  tcnt;
  logic           tlast;
  logic [TW-1:0]  el;
  logic           latched;
  logic [TW-1:0]  hold_len;
  logic [CNT_W-1:0] mrd_eff, mod_eff;
  logic           in_post, post_end;

  assign hold_len = {1'b0, t_wlo} + {1'b0, t_wloe};
  assign mrd_eff  = (t_mrd == '0) ? CNT_W'(1) : t_mrd;
  assign mod_eff  = (t_mod > mrd_eff) ? t_mod : mrd_eff;
  assign in_post  = (state == ST_POST);
  assign post_end = in_post && (el >= {1'b0, mod_eff});

  wlx_phase_timer #(.W(TW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (ld),
    .load_val (ld_val),
    .cnt      (tcnt),
    .last     (tlast)
  );

  always_comb begin
    nxt    = state;
    ld     = 1'b0;
    ld_val = '0;
    case (state)
      ST_IDLE: if (start) begin
        nxt = ST_HOLD; ld = 1'b1; ld_val = hold_len;
      end
      ST_HOLD: if (tlast) begin
        nxt = ST_TIS; ld = 1'b1; ld_val = {1'b0, t_is};
      end
      ST_TIS: if (tlast) begin
        nxt = ST_AOF; ld = 1'b1; ld_val = {1'b0, t_aof};
      end
      ST_AOF:  if (tlast) nxt = ST_MRS;
      ST_MRS:  nxt = ST_POST;
      ST_POST: if (post_end) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      el      <= '0;
      latched <= 1'b0;
      rank_q  <= '0;
    end else begin
      state <= nxt;
      if (state == ST_MRS)  el <= TW'(1);
      else if (in_post)     el <= el + TW'(1);
      else                  el <= '0;
      if (state == ST_IDLE && start) begin
        latched <= 1'b0;
        rank_q  <= rank_in;
      end else if (post_end) begin
        latched <= 1'b1;
      end
    end
  end

  assign dqs_d      = (state == ST_HOLD);
  assign odt_d      = (state == ST_HOLD) && (tcnt > {1'b0, t_odtl_off});
  assign mrs_d      = (state == ST_MRS);
  assign mrs_ok_d   = latched || (in_post && el >= {1'b0, mrd_eff});
  assign cmd_ok_d   = latched || post_end;
  assign done_d     = post_end;
  assign dq_valid_d = dqs_d || cmd_ok_d;
endmodule

// File: rtl/wlx_cmd_out.sv
module wlx_cmd_out
  import wlx_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int BA_W   = 3,
  parameter int RANK_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] mr1_image,
  input  logic              dqs_d,
  input  logic              odt_d,
  input  logic              mrs_d,
  input  logic              mrs_ok_d,
  input  logic              cmd_ok_d,
  input  logic              done_d,
  input  logic              dq_valid_d,
  input  logic [RANK_W-1:0] rank_d,
  output logic              dqs_drive_en,
  output logic              odt,
  output logic [2:0]        cmd,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              dq_valid,
  output logic              mrs_ok,
  output logic              cmd_ok,
  output logic              done,
  output logic [RANK_W-1:0] done_rank
);
  logic [ADDR_W-1:0] mr1_clr;

  for (genvar i = 0; i < ADDR_W; i++) begin : g_mask
    if (i == WL_EN_BIT) begin : g_clr
      assign mr1_clr[i] = 1'b0;
    end else begin : g_keep
      assign mr1_clr[i] = mr1_image[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dqs_drive_en <= 1'b0;
      odt          <= 1'b0;
      cmd          <= CMD_NOP;
      ba           <= '0;
      addr         <= '0;
      dq_valid     <= 1'b0;
      mrs_ok       <= 1'b0;
      cmd_ok       <= 1'b0;
      done         <= 1'b0;
      done_rank    <= '0;
    end else begin
      dqs_drive_en <= dqs_d;
      odt          <= odt_d;
      cmd          <= mrs_d ? CMD_MRS : CMD_NOP;
      ba           <= mrs_d ? BA_W'(MR1_SEL) : '0;
      addr         <= mrs_d ? mr1_clr : '0;
      dq_valid     <= dq_valid_d;
      mrs_ok       <= mrs_ok_d;
      cmd_ok       <= cmd_ok_d;
      done         <= done_d;
      done_rank    <= rank_d;
    end
  end
endmodule

// File: rtl/wlvl_exit_seq.sv
module wlvl_exit_seq #(
  parameter int CNT_W  = 4,
  parameter int RANK_W = 2,
  parameter int ADDR_W = 14,
  parameter int BA_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [RANK_W-1:0] rank_in,
  input  logic [ADDR_W-1:0] mr1_image,
  input  logic [CNT_W-1:0]  t_wlo,
  input  logic [CNT_W-1:0]  t_wloe,
  input  logic [CNT_W-1:0]  t_odtl_off,
  input  logic [CNT_W-1:0]  t_aof,
  input  logic [CNT_W-1:0]  t_is,
  input  logic [CNT_W-1:0]  t_mrd,
  input  logic [CNT_W-1:0]  t_mod,
  output logic              dqs_drive_en,
  output logic              odt,
  output logic [2:0]        cmd,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              dq_valid,
  output logic              mrs_ok,
  output logic              cmd_ok,
  output logic              done,
  output logic [RANK_W-1:0] done_rank
);
  logic dqs_d, odt_d, mrs_d, mrs_ok_d, cmd_ok_d, done_d, dq_valid_d;
  logic [RANK_W-1:0] rank_q;

  wlx_seq_fsm #(.CNT_W(CNT_W), .RANK_W(RANK_W)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .rank_in    (rank_in),
    .t_wlo      (t_wlo),
    .t_wloe     (t_wloe),
    .t_odtl_off (t_odtl_off),
    .t_aof      (t_aof),
    .t_is       (t_is),
    .t_mrd      (t_mrd),
    .t_mod      (t_mod),
    .dqs_d      (dqs_d),
    .odt_d      (odt_d),
    .mrs_d      (mrs_d),
    .mrs_ok_d   (mrs_ok_d),
    .cmd_ok_d   (cmd_ok_d),
    .done_d     (done_d),
    .dq_valid_d (dq_valid_d),
    .rank_q     (rank_q)
  );

  wlx_cmd_out #(.ADDR_W(ADDR_W), .BA_W(BA_W), .RANK_W(RANK_W)) u_out (
    .clk          (clk),
    .rst          (rst),
    .mr1_image    (mr1_image),
    .dqs_d        (dqs_d),
    .odt_d        (odt_d),
    .mrs_d        (mrs_d),
    .mrs_ok_d     (mrs_ok_d),
    .cmd_ok_d     (cmd_ok_d),
    .done_d       (done_d),
    .dq_valid_d   (dq_valid_d),
    .rank_d       (rank_q),
    .dqs_drive_en (dqs_drive_en),
    .odt          (odt),
    .cmd          (cmd),
    .ba           (ba),
    .addr         (addr),
    .dq_valid     (dq_valid),
    .mrs_ok       (mrs_ok),
    .cmd_ok       (cmd_ok),
    .done         (done),
    .done_rank    (done_rank)
  );
endmodule

// File: rtl/wlx_exit_chk.sv
module wlx_exit_chk
  import wlx_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int BA_W   = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              dqs_drive_en,
  input logic              odt,
  input logic [2:0]        cmd,
  input logic [BA_W-1:0]   ba,
  input logic [ADDR_W-1:0] addr,
  input logic              dq_valid,
  input logic              mrs_ok,
  input logic              cmd_ok,
  input logic              done
);
  // R4
  mrs_single_chk: assert property (@(posedge clk) disable iff (rst)
    cmd == CMD_MRS |=> cmd == CMD_NOP);
  // R4
  mrs_after_teardown_chk: assert property (@(posedge clk) disable iff (rst)
    cmd == CMD_MRS |-> (!odt && !dqs_drive_en));
  // R3
  odt_low_at_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(dqs_drive_en) |-> !odt);
  // R3
  odt_within_drive_chk: assert property (@(posedge clk) disable iff (rst)
    odt |-> dqs_drive_en);
  // R5
  mrs_fields_chk: assert property (@(posedge clk) disable iff (rst)
    cmd == CMD_MRS |-> (ba == BA_W'(MR1_SEL) && !addr[WL_EN_BIT]));
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R7
  done_with_gate_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> ($rose(cmd_ok) && mrs_ok));
  // R8
  dq_masked_at_mrs_chk: assert property (@(posedge clk) disable iff (rst)
    cmd == CMD_MRS |-> !dq_valid);
  // R6
  gate_order_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_ok |-> mrs_ok);
endmodule

bind wlvl_exit_seq wlx_exit_chk #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .dqs_drive_en (dqs_drive_en),
  .odt          (odt),
  .cmd          (cmd),
  .ba           (ba),
  .addr         (addr),
  .dq_valid     (dq_valid),
  .mrs_ok       (mrs_ok),
  .cmd_ok       (cmd_ok),
  .done         (done)
);

// File: tb/test_wlvl_exit_seq.sv
module test_wlvl_exit_seq;
  localparam int CNT_W = 4, RANK_W = 2, ADDR_W = 14, BA_W = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, start;
  logic [RANK_W-1:0] rank_in;
  logic [ADDR_W-1:0] mr1_image;
  logic [CNT_W-1:0] t_wlo, t_wloe, t_odtl_off, t_aof, t_is, t_mrd, t_mod;
  logic dqs_drive_en, odt, dq_valid, mrs_ok, cmd_ok, done;
  logic [2:0] cmd;
  logic [BA_W-1:0] ba;
  logic [ADDR_W-1:0] addr;
  logic [RANK_W-1:0] done_rank;

  int checks = 0, failures = 0;
  bit finished = 0;

  wlvl_exit_seq #(.CNT_W(CNT_W), .RANK_W(RANK_W), .ADDR_W(ADDR_W), .BA_W(BA_W))
  i_wlvl_exit_seq (
    .clk(clk), .rst(rst), .start(start), .rank_in(rank_in), .mr1_image(mr1_image),
    .t_wlo(t_wlo), .t_wloe(t_wloe), .t_odtl_off(t_odtl_off), .t_aof(t_aof),
    .t_is(t_is), .t_mrd(t_mrd), .t_mod(t_mod),
    .dqs_drive_en(dqs_drive_en), .odt(odt), .cmd(cmd), .ba(ba), .addr(addr),
    .dq_valid(dq_valid), .mrs_ok(mrs_ok), .cmd_ok(cmd_ok), .done(done),
    .done_rank(done_rank)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic chk_idle_outputs(input string req);
    chk(dqs_drive_en == 1'b0, req, "dqs_drive_en", int'(dqs_drive_en), 0);
    chk(odt == 1'b0, req, "odt", int'(odt), 0);
    chk(cmd == 3'b111, req, "cmd", int'(cmd), 7);
    chk(ba == '0 && addr == '0, req, "ba|addr", int'(ba) + int'(addr), 0);
    chk(mrs_ok == 1'b0 && cmd_ok == 1'b0, req, "mrs_ok+cmd_ok",
        int'(mrs_ok) + int'(cmd_ok), 0);
    chk(done == 1'b0 && dq_valid == 1'b0, req, "done+dq_valid",
        int'(done) + int'(dq_valid), 0);
    chk(done_rank == '0, req, "done_rank", int'(done_rank), 0);
  endtask

  task automatic run_case(input int wlo, input int wloe, input int lofs,
                          input int tis, input int taof, input int tmrd,
                          input int tmod, input bit poke, input int rk,
                          input logic [ADDR_W-1:0] mr, input bit had_prev);
    int w, h, ia, aa, s, mr_e, mo_e, odt_hi, mrs_cnt, last_t;
    logic [ADDR_W-1:0] mr_exp;
    w = wlo + wloe;
    h = (w < 1) ? 1 : w;
    ia = (tis < 1) ? 1 : tis;
    aa = (taof < 1) ? 1 : taof;
    s = h + ia + aa;
    mr_e = (tmrd < 1) ? 1 : tmrd;
    mo_e = (tmod > mr_e) ? tmod : mr_e;
    odt_hi = w - lofs;
    mr_exp = mr & ~(ADDR_W'(1) << 7);
    mrs_cnt = 0;
    last_t = s + mo_e + 3;

    @(negedge clk);
    t_wlo = CNT_W'(wlo); t_wloe = CNT_W'(wloe); t_odtl_off = CNT_W'(lofs);
    t_is = CNT_W'(tis); t_aof = CNT_W'(taof); t_mrd = CNT_W'(tmrd); t_mod = CNT_W'(tmod);
    mr1_image = mr; rank_in = RANK_W'(rk); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // t = 0: flags still show the previous finished sequence (R10)
    if (had_prev)
      chk(cmd_ok == 1'b1 && mrs_ok == 1'b1 && dq_valid == 1'b1, "R10",
          "flags held before new start", int'(cmd_ok), 1);
    if (poke) rank_in = RANK_W'(rk + 1);
    for (int t = 1; t <= last_t; t++) begin
      bit e_dqs, e_odt, e_mrs, e_mok, e_cok, e_done, e_dqv;
      @(negedge clk);
      e_dqs  = (t >= 1 && t <= h);
      e_odt  = (t >= 1 && t <= odt_hi);
      e_mrs  = (t == s + 1);
      e_mok  = (t >= s + 1 + mr_e);
      e_cok  = (t >= s + 1 + mo_e);
      e_done = (t == s + 1 + mo_e);
      e_dqv  = e_dqs || e_cok;
      chk(dqs_drive_en == e_dqs, "R2", "dqs_drive_en", int'(dqs_drive_en), int'(e_dqs));
      chk(odt == e_odt, "R3", "odt", int'(odt), int'(e_odt));
      chk(cmd == (e_mrs ? 3'b000 : 3'b111), "R4", "cmd", int'(cmd),
          e_mrs ? 0 : 7);
      chk(ba == (e_mrs ? BA_W'(1) : '0), "R5", "ba", int'(ba), e_mrs ? 1 : 0);
      chk(addr == (e_mrs ? mr_exp : '0), "R5", "addr", int'(addr),
          e_mrs ? int'(mr_exp) : 0);
      chk(mrs_ok == e_mok, "R6", "mrs_ok", int'(mrs_ok), int'(e_mok));
      chk(cmd_ok == e_cok, "R7", "cmd_ok", int'(cmd_ok), int'(e_cok));
      chk(done == e_done, "R7", "done", int'(done), int'(e_done));
      if (e_done)
        chk(done_rank == RANK_W'(rk), "R7", "done_rank", int'(done_rank), rk % 4);
      chk(dq_valid == e_dqv, "R8", "dq_valid", int'(dq_valid), int'(e_dqv));
      if (cmd == 3'b000) mrs_cnt++;
      // busy-time start pulse, sampled while the sequence is running (R9)
      start = (poke && t == 2);
    end
    start = 1'b0;
    if (poke) begin
      chk(mrs_cnt == 1, "R9", "MRS count with busy start", mrs_cnt, 1);
      chk(done_rank == RANK_W'(rk), "R9", "rank kept", int'(done_rank), rk % 4);
    end
    chk(cmd_ok && mrs_ok && dq_valid && !done, "R10", "flags hold after done",
        int'(cmd_ok) + int'(mrs_ok) + int'(dq_valid) + int'(done), 3);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int run;
    rst = 1'b1; start = 1'b0; rank_in = '0; mr1_image = '0;
    t_wlo = '0; t_wloe = '0; t_odtl_off = '0; t_aof = '0;
    t_is = '0; t_mrd = '0; t_mod = '0;
    repeat (3) @(negedge clk);
    chk_idle_outputs("R1");
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk_idle_outputs("R1");

    run = 0;
    for (int wlo = 0; wlo <= 2; wlo++)
      for (int wloe = 0; wloe <= 2; wloe++)
        for (int lofs = 0; lofs <= 3; lofs++)
          for (int tis = 0; tis <= 1; tis++)
            for (int taof = 0; taof <= 2; taof += 2)
              for (int tmrd = 0; tmrd <= 2; tmrd += 2)
                for (int tmod = 0; tmod <= 4; tmod += (tmod == 0 ? 1 : 3)) begin
                  run_case(wlo, wloe, lofs, tis, taof, tmrd, tmod, run[0],
                           run % 4, ADDR_W'(14'h3fff ^ (run * 37)), run != 0);
                  run++;
                end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule